// File: doc/BRIEF.md
# Batched flash operation list executor

This block walks a table of operation descriptors held in ordinary memory and runs them one after another, so a caller can hand over a whole batch of flash work with a single start pulse. Every descriptor is six 32-bit words; the block reads the first five, decodes the opcode, forms the flash-relative addresses and hands the operation to an external flash command sequencer over a start/done/result handshake.

When the sequencer reports back, the signed result is written into the sixth word of the same descriptor and added to a running total. Then the pointer moves on by one descriptor. A terminating opcode ends the run with a done pulse and the total. A restart opcode ends the run with a restart request toward a fixed boot vector. A list that never terminates is cut off after a parameterised number of operations and flagged.

Top module: `flb_exec`

## Requirements
- R1: After reset `busy_o`, `done_o`, `restart_o`, `overflow_o`, `mem_req_valid_o`, `mem_wr_valid_o` and `seq_start_o` are 0 and `total_o` is 0.
- R2: A descriptor at byte address P is read as five words at P, P+4, P+8, P+12 and P+16, in that order, with one read outstanding at a time. Their meanings in order are opcode, flash base, destination, source and count.
- R3: Opcode bits [7:4] give the class, where 1 is read, 2 is query, 3 is erase, 4 is program and 5 is identify. For read, query and identify, `seq_tgt_o` is source plus base and `seq_other_o` is the destination. For erase and program, `seq_tgt_o` is destination plus base and `seq_other_o` is the source.
- R4: Opcode bits [1:0] give the bus mode, where 0 is 8-bit, 1 is 16-bit and 2 is 16-bit byte-lane. Each unlock address on `seq_unlock_o` is base plus its command offset (0x555 in slot 0, 0x2AA in slot 1). In byte-lane mode that offset is shifted left by one.
- R5: Opcode 0x00 ends the run with a one-cycle `done_o` pulse and the final total. That descriptor gets no writeback and no sequencer start.
- R6: Opcode 0x01 ends the run with a one-cycle `restart_o` pulse, no `done_o` and no writeback. `restart_vec_o` carries the boot vector 0x1FC00000.
- R7: Any other opcode that is not a class of R3 with a mode of R4, with bits [3:2] zero and bits [31:8] zero, writes a result of -1 without starting the sequencer.
- R8: Each executed descriptor gets its result written to word P+20, and `total_o` holds the signed sum of all results written in the run.
- R9: The next descriptor starts 24 bytes after the current one.
- R10: After MAX_OPS written descriptors without a terminating opcode, the run ends with a `done_o` pulse and `overflow_o` at 1. A list that terminates within MAX_OPS leaves `overflow_o` at 0.
- R11: The writeback of a descriptor completes before any read of the next descriptor, and a read request and a write request are never raised together.
- R12: `seq_start_o` is a one-cycle pulse, and the sequencer fields stay stable until `seq_done_i` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (ignored while busy) |
| list_addr_i | input | AW | Byte address of the first descriptor |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at normal or cut-off end |
| total_o | output | DW | Signed sum of results of the run |
| overflow_o | output | 1 | Run was cut off at MAX_OPS |
| restart_o | output | 1 | One-cycle restart request |
| restart_vec_o | output | AW | Boot vector for the restart |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | AW | Read byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | DW | Read data |
| mem_wr_valid_o | output | 1 | Result write valid |
| mem_wr_ready_i | input | 1 | Result write accepted |
| mem_wr_addr_o | output | AW | Result write byte address |
| mem_wr_data_o | output | DW | Result value |
| seq_start_o | output | 1 | Start pulse to the flash sequencer |
| seq_cls_o | output | 4 | Operation class |
| seq_wmode_o | output | 2 | Bus mode |
| seq_tgt_o | output | AW | Base-adjusted flash address |
| seq_other_o | output | AW | Unadjusted memory-side address |
| seq_cnt_o | output | DW | Byte count |
| seq_unlock_o | output | NUM_UNLOCK*AW | Unlock command addresses, slot 0 in the low bits |
| seq_done_i | input | 1 | Sequencer finished |
| seq_result_i | input | DW | Signed sequencer result |

## Verification
A wrong fetch word counter or pointer shows up at the very next read handshake as an out-of-order address, and a wrong class decode shows up on the first sequencer start as a target address without the base or with a mis-scaled unlock address. Accumulator or result faults appear at the writeback of the affected descriptor and in `total_o` at the end pulse. A broken operation counter shows up only at the end of a run, so lists of exactly MAX_OPS-1 and MAX_OPS operations are run to expose an off-by-one in the cut-off.

// File: rtl/flb_pkg.sv
package flb_pkg;
  typedef enum logic [3:0] {
    CLS_NONE  = 4'd0,
    CLS_READ  = 4'd1,
    CLS_QUERY = 4'd2,
    CLS_ERASE = 4'd3,
    CLS_PROG  = 4'd4,
    CLS_IDENT = 4'd5
  } op_cls_e;

  typedef enum logic [1:0] {
    WM_X8  = 2'd0,
    WM_X16 = 2'd1,
    WM_X16B = 2'd2,
    WM_BAD = 2'd3
  } wmode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FRSP, S_DECODE, S_DISP, S_WAIT, S_WRITE
  } st_e;

  localparam int unsigned N_FETCH = 5;  // opcode, base, dest, src, count
  localparam int unsigned N_WORDS = 6;  // plus result
endpackage

// File: rtl/flb_decode.sv
module flb_decode
  import flb_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] op_i,
  output logic          ret_o,
  output logic          boot_o,
  output logic          valid_o,
  output logic          on_src_o,
  output op_cls_e       cls_o,
  output wmode_e        wmode_o
);
  logic hi_zero, known;

  assign cls_o   = op_cls_e'(op_i[7:4]);
  assign wmode_o = wmode_e'(op_i[1:0]);
  assign hi_zero = (op_i[DW-1:8] == '0);
  assign known   = cls_o inside {CLS_READ, CLS_QUERY, CLS_ERASE, CLS_PROG, CLS_IDENT};

  assign ret_o    = (op_i == '0);
  assign boot_o   = (op_i == DW'(1));
  assign valid_o  = hi_zero && (op_i[3:2] == 2'b00) && (wmode_o != WM_BAD) && known;
  assign on_src_o = cls_o inside {CLS_READ, CLS_QUERY, CLS_IDENT};
endmodule

// File: rtl/flb_addr.sv
module flb_addr
  import flb_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned NUM_UNLOCK = 2,
  parameter logic [NUM_UNLOCK*AW-1:0] UNLOCK_OFFS = {32'h0000_02AA, 32'h0000_0555}
) (
  input  logic [AW-1:0]            base_i,
  input  logic [AW-1:0]            dst_i,
  input  logic [AW-1:0]            src_i,
  input  wmode_e                   wmode_i,
  input  logic                     on_src_i,
  output logic [AW-1:0]            tgt_o,
  output logic [AW-1:0]            other_o,
  output logic [NUM_UNLOCK*AW-1:0] unlock_o
);
  logic lane;

  assign lane    = (wmode_i == WM_X16B);
  assign tgt_o   = (on_src_i ? src_i : dst_i) + base_i;
  assign other_o = on_src_i ? dst_i : src_i;

  // byte-lane parts see command offsets doubled
  for (genvar g = 0; g < NUM_UNLOCK; g++) begin : g_unl
    logic [AW-1:0] off;
    assign off = UNLOCK_OFFS[g*AW +: AW];
    assign unlock_o[g*AW +: AW] = base_i + (lane ? (off << 1) : off);
  end
endmodule

// File: rtl/flb_exec.sv
module flb_exec
  import flb_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned MAX_OPS = 64,
  parameter int unsigned NUM_UNLOCK = 2,
  parameter logic [NUM_UNLOCK*AW-1:0] UNLOCK_OFFS = {32'h0000_02AA, 32'h0000_0555},
  parameter logic [AW-1:0] BOOT_VEC = 32'h1FC0_0000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [AW-1:0]            list_addr_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic signed [DW-1:0]     total_o,
  output logic                     overflow_o,
  output logic                     restart_o,
  output logic [AW-1:0]            restart_vec_o,
  output logic                     mem_req_valid_o,
  input  logic                     mem_req_ready_i,
  output logic [AW-1:0]            mem_req_addr_o,
  input  logic                     mem_rsp_valid_i,
  input  logic [DW-1:0]            mem_rsp_data_i,
  output logic                     mem_wr_valid_o,
  input  logic                     mem_wr_ready_i,
  output logic [AW-1:0]            mem_wr_addr_o,
  output logic [DW-1:0]            mem_wr_data_o,
  output logic                     seq_start_o,
  output logic [3:0]               seq_cls_o,
  output logic [1:0]               seq_wmode_o,
  output logic [AW-1:0]            seq_tgt_o,
  output logic [AW-1:0]            seq_other_o,
  output logic [DW-1:0]            seq_cnt_o,
  output logic [NUM_UNLOCK*AW-1:0] seq_unlock_o,
  input  logic                     seq_done_i,
  input  logic signed [DW-1:0]     seq_result_i
);
  localparam int unsigned WB      = DW / 8;
  localparam int unsigned WSH     = $clog2(WB);
  localparam int unsigned DESC_B  = N_WORDS * WB;
  localparam int unsigned RES_OFF = N_FETCH * WB;
  localparam int unsigned NW      = $clog2(MAX_OPS + 1);
  localparam int unsigned IW      = $clog2(N_FETCH + 1);

  st_e                   state;
  logic [AW-1:0]         ptr;
  logic [IW-1:0]         widx;
  logic [NW-1:0]         nops;
  logic [DW-1:0]         fld [N_FETCH];
  logic signed [DW-1:0]  result, total;
  logic                  done_q, restart_q, ovf_q;

  logic    d_ret, d_boot, d_valid, d_on_src;
  op_cls_e d_cls;
  wmode_e  d_wm;

  flb_decode #(.DW(DW)) u_dec (
    .op_i(fld[0]), .ret_o(d_ret), .boot_o(d_boot), .valid_o(d_valid),
    .on_src_o(d_on_src), .cls_o(d_cls), .wmode_o(d_wm)
  );

  flb_addr #(.AW(AW), .NUM_UNLOCK(NUM_UNLOCK), .UNLOCK_OFFS(UNLOCK_OFFS)) u_addr (
    .base_i(fld[1][AW-1:0]), .dst_i(fld[2][AW-1:0]), .src_i(fld[3][AW-1:0]),
    .wmode_i(d_wm), .on_src_i(d_on_src),
    .tgt_o(seq_tgt_o), .other_o(seq_other_o), .unlock_o(seq_unlock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= S_IDLE;
      ptr       <= '0;
      widx      <= '0;
      nops      <= '0;
      result    <= '0;
      total     <= '0;
      done_q    <= 1'b0;
      restart_q <= 1'b0;
      ovf_q     <= 1'b0;
      for (int i = 0; i < N_FETCH; i++) fld[i] <= '0;
    end else begin
      done_q    <= 1'b0;
      restart_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) begin
          ptr   <= list_addr_i;
          widx  <= '0;
          nops  <= '0;
          total <= '0;
          ovf_q <= 1'b0;
          state <= S_FETCH;
        end
        S_FETCH: if (mem_req_ready_i) state <= S_FRSP;
        S_FRSP: if (mem_rsp_valid_i) begin
          fld[widx] <= mem_rsp_data_i;
          if (widx == IW'(N_FETCH - 1)) begin
            widx  <= '0;
            state <= S_DECODE;
          end else begin
            widx  <= widx + 1'b1;
            state <= S_FETCH;
          end
        end
        S_DECODE: begin
          if (d_ret) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (d_boot) begin
            restart_q <= 1'b1;
            state     <= S_IDLE;
          end else if (d_valid) begin
            state <= S_DISP;
          end else begin
            result <= '1;
            state  <= S_WRITE;
          end
        end
        S_DISP: state <= S_WAIT;
        S_WAIT: if (seq_done_i) begin
          result <= seq_result_i;
          state  <= S_WRITE;
        end
        S_WRITE: if (mem_wr_ready_i) begin
          total <= total + result;
          ptr   <= ptr + AW'(DESC_B);
          if (nops == NW'(MAX_OPS - 1)) begin
            ovf_q  <= 1'b1;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            nops  <= nops + 1'b1;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o          = (state != S_IDLE);
  assign done_o          = done_q;
  assign restart_o       = restart_q;
  assign restart_vec_o   = BOOT_VEC;
  assign overflow_o      = ovf_q;
  assign total_o         = total;
  assign mem_req_valid_o = (state == S_FETCH);
  assign mem_req_addr_o  = ptr + (AW'(widx) << WSH);
  assign mem_wr_valid_o  = (state == S_WRITE);
  assign mem_wr_addr_o   = ptr + AW'(RES_OFF);
  assign mem_wr_data_o   = result;
  assign seq_start_o     = (state == S_DISP);
  assign seq_cls_o       = d_cls;
  assign seq_wmode_o     = d_wm;
  assign seq_cnt_o       = fld[4];
endmodule

// File: rtl/flb_exec_chk.sv
module flb_exec_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          restart_o,
  input logic          overflow_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic [AW-1:0] mem_req_addr_o,
  input logic          mem_wr_valid_o,
  input logic          mem_wr_ready_i,
  input logic [AW-1:0] mem_wr_addr_o,
  input logic [DW-1:0] mem_wr_data_o,
  input logic          seq_start_o,
  input logic [AW-1:0] seq_tgt_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_valid_o && !mem_wr_valid_o && !seq_start_o));

  p_rd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_end_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && restart_o));

  p_wr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && !mem_wr_ready_i) |=>
      (mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));

  p_ovf_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> done_o);

  p_rd_wr_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_valid_o && mem_wr_valid_o));

  p_start_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_o |=> !seq_start_o);

  p_start_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_o |=> $stable(seq_tgt_o));
endmodule

bind flb_exec flb_exec_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .restart_o(restart_o), .overflow_o(overflow_o),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o(mem_req_addr_o), .mem_wr_valid_o(mem_wr_valid_o),
  .mem_wr_ready_i(mem_wr_ready_i), .mem_wr_addr_o(mem_wr_addr_o),
  .mem_wr_data_o(mem_wr_data_o), .seq_start_o(seq_start_o), .seq_tgt_o(seq_tgt_o)
);

// File: tb/flb_exec_test.sv
`timescale 1ns/1ps
module flb_exec_test;
  localparam int MAXB = 8;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [31:0] list_addr_i = '0;
  logic busy_o, done_o, overflow_o, restart_o;
  logic signed [31:0] total_o;
  logic [31:0] restart_vec_o;
  logic mem_req_valid_o, mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic mem_wr_valid_o, mem_wr_ready_i = 1'b0;
  logic [31:0] mem_wr_addr_o, mem_wr_data_o;
  logic seq_start_o;
  logic [3:0] seq_cls_o;
  logic [1:0] seq_wmode_o;
  logic [31:0] seq_tgt_o, seq_other_o, seq_cnt_o;
  logic [63:0] seq_unlock_o;
  logic seq_done_i = 1'b0;
  logic signed [31:0] seq_result_i = '0;

  always #4 clk = ~clk;  // 125 MHz

  flb_exec #(.AW(32), .DW(32), .MAX_OPS(MAXB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .list_addr_i(list_addr_i),
    .busy_o(busy_o), .done_o(done_o), .total_o(total_o), .overflow_o(overflow_o),
    .restart_o(restart_o), .restart_vec_o(restart_vec_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .mem_wr_valid_o(mem_wr_valid_o),
    .mem_wr_ready_i(mem_wr_ready_i), .mem_wr_addr_o(mem_wr_addr_o),
    .mem_wr_data_o(mem_wr_data_o), .seq_start_o(seq_start_o), .seq_cls_o(seq_cls_o),
    .seq_wmode_o(seq_wmode_o), .seq_tgt_o(seq_tgt_o), .seq_other_o(seq_other_o),
    .seq_cnt_o(seq_cnt_o), .seq_unlock_o(seq_unlock_o), .seq_done_i(seq_done_i),
    .seq_result_i(seq_result_i)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [256];
  logic [31:0] d_op [16], d_base [16], d_dst [16], d_src [16], d_cnt [16];
  logic [31:0] cur_lb;
  int rd_cnt, wr_cnt, st_cnt;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit op_valid(input logic [31:0] op);
    return (op[31:8] == 0) && (op[3:2] == 0) && (op[1:0] != 3) && (op[7:4] >= 1) && (op[7:4] <= 5);
  endfunction

  function automatic logic [31:0] seq_res(input logic [31:0] c);
    return c[7] ? -(32'(c[2:0]) + 32'd1) : 32'd0;
  endfunction

  function automatic logic [31:0] exp_res(input int k);
    return op_valid(d_op[k]) ? seq_res(d_cnt[k]) : 32'hFFFF_FFFF;
  endfunction

  function automatic bit on_src(input logic [31:0] op);
    return op[7:4] == 1 || op[7:4] == 2 || op[7:4] == 5;
  endfunction

  function automatic logic [31:0] exp_unl(input int k, input int j);
    logic [31:0] off;
    off = (j == 0) ? 32'h555 : 32'h2AA;
    return d_base[k] + ((d_op[k][1:0] == 2) ? (off << 1) : off);
  endfunction

  // memory model
  initial begin
    int k, w;
    forever begin
      @(posedge clk);
      if (rst_ni) begin
        if (mem_req_valid_o && mem_req_ready_i) begin
          k = rd_cnt / 5; w = rd_cnt % 5;
          chk(mem_req_addr_o == cur_lb + 24*k + 4*w, (w == 0) ? "R9 next descriptor" : "R2 fetch order",
              mem_req_addr_o, cur_lb + 24*k + 4*w);
          if (w == 0 && k > 0) chk(wr_cnt == k, "R11 writeback before fetch", wr_cnt, k);
          mem_rsp_data_i  <= mem[mem_req_addr_o[9:2]];
          mem_rsp_valid_i <= 1'b1;
          rd_cnt++;
        end else mem_rsp_valid_i <= 1'b0;
        if (mem_wr_valid_o && mem_wr_ready_i) begin
          chk(mem_wr_addr_o == cur_lb + 24*wr_cnt + 20, "R8 result address", mem_wr_addr_o, cur_lb + 24*wr_cnt + 20);
          chk(mem_wr_data_o == exp_res(wr_cnt), op_valid(d_op[wr_cnt]) ? "R8 result value" : "R7 invalid gives -1",
              mem_wr_data_o, exp_res(wr_cnt));
          mem[mem_wr_addr_o[9:2]] = mem_wr_data_o;
          wr_cnt++;
        end
      end
      mem_req_ready_i <= ($urandom % 4) != 0;
      mem_wr_ready_i  <= ($urandom % 3) != 0;
    end
  end

  // flash sequencer model
  initial begin
    int k, left;
    logic [31:0] cap_tgt, cap_oth;
    left = 0;
    forever begin
      @(posedge clk);
      seq_done_i <= 1'b0;
      if (rst_ni && seq_start_o) begin
        k = rd_cnt / 5 - 1;
        st_cnt++;
        chk(op_valid(d_op[k]), "R7 dispatch only for valid op", d_op[k], 0);
        chk(seq_tgt_o == (on_src(d_op[k]) ? d_src[k] : d_dst[k]) + d_base[k], "R3 target address",
            seq_tgt_o, (on_src(d_op[k]) ? d_src[k] : d_dst[k]) + d_base[k]);
        chk(seq_other_o == (on_src(d_op[k]) ? d_dst[k] : d_src[k]), "R3 other address",
            seq_other_o, on_src(d_op[k]) ? d_dst[k] : d_src[k]);
        chk(seq_cls_o == d_op[k][7:4] && seq_wmode_o == d_op[k][1:0] && seq_cnt_o == d_cnt[k],
            "R3 class mode count", {seq_cls_o, seq_wmode_o, seq_cnt_o}, {d_op[k][7:4], d_op[k][1:0], d_cnt[k]});
        chk(seq_unlock_o[31:0] == exp_unl(k, 0), "R4 unlock slot 0", seq_unlock_o[31:0], exp_unl(k, 0));
        chk(seq_unlock_o[63:32] == exp_unl(k, 1), "R4 unlock slot 1", seq_unlock_o[63:32], exp_unl(k, 1));
        cap_tgt = seq_tgt_o; cap_oth = seq_other_o;
        left = 1 + int'($urandom % 4);
        seq_result_i <= seq_res(d_cnt[k]);
      end else if (rst_ni && left > 0) begin
        chk(!seq_start_o, "R12 start is a pulse", seq_start_o, 0);
        left--;
        if (left == 0) begin
          chk(seq_tgt_o == cap_tgt && seq_other_o == cap_oth, "R12 fields stable", seq_tgt_o, cap_tgt);
          seq_done_i <= 1'b1;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  task automatic set_desc(input int k, input logic [31:0] op);
    d_op[k] = op; d_base[k] = $urandom & 32'h00FF_F000;
    d_dst[k] = $urandom & 32'h000F_FFFF; d_src[k] = $urandom & 32'h000F_FFFF;
    d_cnt[k] = $urandom;
  endtask

  function automatic logic [31:0] rnd_op();
    logic [31:0] bad [4] = '{32'h13, 32'h60, 32'h14, 32'h121};
    if ($urandom % 5 == 0) return bad[$urandom % 4];
    return {24'd0, 4'(1 + $urandom % 5), 2'b00, 2'($urandom % 3)};
  endfunction

  task automatic run_list(input int n, input logic [31:0] lb);
    int e_wr = 0, e_st = 0, e_fetch = 0, t = 0;
    logic [31:0] e_sum = 0;
    bit e_done = 0, e_boot = 0, e_ovf = 0, saw_done = 0, saw_boot = 0, ovf_at = 0;
    logic [31:0] tot_at = 0, vec_at = 0;
    for (int k = 0; k < n; k++) begin
      e_fetch++;
      if (d_op[k] == 0) begin e_done = 1; break; end
      if (d_op[k] == 1) begin e_boot = 1; break; end
      e_wr++; if (op_valid(d_op[k])) e_st++;
      e_sum += exp_res(k);
      if (e_wr == MAXB) begin e_ovf = 1; e_done = 1; break; end
    end
    for (int k = 0; k < n; k++) begin
      mem[lb[9:2] + 8'(6*k)]     = d_op[k];
      mem[lb[9:2] + 8'(6*k + 1)] = d_base[k];
      mem[lb[9:2] + 8'(6*k + 2)] = d_dst[k];
      mem[lb[9:2] + 8'(6*k + 3)] = d_src[k];
      mem[lb[9:2] + 8'(6*k + 4)] = d_cnt[k];
      mem[lb[9:2] + 8'(6*k + 5)] = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    cur_lb = lb; rd_cnt = 0; wr_cnt = 0; st_cnt = 0;
    list_addr_i = lb; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (!saw_done && !saw_boot && t < 4000) begin
      if (done_o) begin saw_done = 1; ovf_at = overflow_o; tot_at = total_o; end
      if (restart_o) begin saw_boot = 1; vec_at = restart_vec_o; end
      if (!saw_done && !saw_boot) begin @(negedge clk); t++; end
    end
    chk(saw_done == e_done, e_ovf ? "R10 done at cut-off" : "R5 done pulse", saw_done, e_done);
    chk(saw_boot == e_boot, "R6 restart pulse", saw_boot, e_boot);
    if (e_boot) chk(vec_at == 32'h1FC0_0000, "R6 boot vector", vec_at, 32'h1FC0_0000);
    if (e_done) begin
      chk(tot_at == e_sum, "R8 total", tot_at, e_sum);
      chk(ovf_at == e_ovf, "R10 overflow flag", ovf_at, e_ovf);
    end
    @(negedge clk);
    chk(!done_o && !restart_o && !busy_o, "R5 R6 end pulse one cycle", {done_o, restart_o, busy_o}, 0);
    repeat (4) @(negedge clk);
    chk(wr_cnt == e_wr, "R5 writebacks", wr_cnt, e_wr);
    chk(st_cnt == e_st, "R7 sequencer starts", st_cnt, e_st);
    chk(rd_cnt == 5 * e_fetch, "R2 word reads", rd_cnt, 5 * e_fetch);
    if (e_wr < n) chk(mem[lb[9:2] + 8'(6*e_wr + 5)] == 32'hDEAD_BEEF, "R5 terminator untouched",
                      mem[lb[9:2] + 8'(6*e_wr + 5)], 32'hDEAD_BEEF);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    cur_lb = 0; rd_cnt = 0; wr_cnt = 0; st_cnt = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !restart_o && !overflow_o && total_o == 0, "R1 reset outputs",
        {busy_o, done_o, restart_o, overflow_o, total_o}, 0);
    chk(!mem_req_valid_o && !mem_wr_valid_o && !seq_start_o, "R1 reset requests",
        {mem_req_valid_o, mem_wr_valid_o, seq_start_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // directed mix: every mode, both address sides, invalid in the middle
    set_desc(0, 32'h10); set_desc(1, 32'h32); set_desc(2, 32'h33);
    set_desc(3, 32'h41); set_desc(4, 32'h52); set_desc(5, 32'h22);
    d_cnt[1] = 32'h85; set_desc(6, 32'h00);
    run_list(7, 32'd64);

    // terminator first
    set_desc(0, 32'h00); run_list(1, 32'd128);

    // restart after one op
    set_desc(0, 32'h21); set_desc(1, 32'h01); set_desc(2, 32'h10);
    run_list(3, 32'd200);

    // invalid patterns (R7)
    set_desc(0, 32'h13); set_desc(1, 32'h60); set_desc(2, 32'h14);
    set_desc(3, 32'h121); set_desc(4, 32'h00);
    run_list(5, 32'd32);

    // boundary: MAXB-1 ops then terminator, no overflow (R10)
    for (int k = 0; k < MAXB - 1; k++) set_desc(k, 32'h40);
    set_desc(MAXB - 1, 32'h00);
    run_list(MAXB, 32'd16);

    // MAXB ops with no terminator reachable (R10)
    for (int k = 0; k < MAXB; k++) set_desc(k, 32'h31);
    set_desc(MAXB, 32'h00);
    run_list(MAXB + 1, 32'd0);

    // random lists
    for (int r = 0; r < 12; r++) begin
      int n;
      n = 1 + int'($urandom % 7);
      for (int k = 0; k < n - 1; k++) set_desc(k, rnd_op());
      set_desc(n - 1, 32'h00);
      run_list(n, 32'(4 * ($urandom % 16)));
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule